// File: doc/BRIEF.md
# Serial Bulk-Program Memory Responder

This block is the target side of a three-wire serial memory link that holds 64 words of 16 bits in plain registers. A host frames an instruction with chip select held high, clocks bits in on the rising edge of the serial clock, and closes the frame by dropping chip select. Two instructions act on the whole array: one fills every bit with 1, the other copies one 16-bit word into every location.

Dropping chip select at the end of a valid frame starts an internal programming period of a fixed number of system clocks. The host polls for completion over the data-out line. It holds chip select low for at least a minimum number of clocks, then raises it. Data-out then drives 0 while programming is still running and 1 once it has finished. Data-out is undriven at all other times. The serial inputs are synchronized into the system clock. A parallel word read port exposes the array contents.

Top module: `mwb_bulk_prog`

## Requirements
- R1: After reset every array word reads 0, the data-out enable is low and no programming period is running.
- R2: A frame consisting of a start bit 1, opcode 00 and a 6-bit address whose two most significant bits are 10 (exactly 9 bits in total, low address bits ignored) sets every word to 16'hFFFF.
- R3: A frame consisting of a start bit 1, opcode 00, a 6-bit address whose top two bits are 01, and then 16 data bits MSB first (exactly 25 bits) loads every word with that data value.
- R4: The data-out enable is low while an instruction is being shifted in, and whenever chip select is low.
- R5: Programming begins when chip select falls after the last bit of a valid frame and lasts PROG_CYC system clocks. Ready is seen exactly PROG_CYC+3 clocks after the chip-select pin falls, counting the synchronizer and the edge-detect register.
- R6: When chip select rises after being low for at least TCS_CYC clocks following a valid frame, data-out is enabled and drives 0 while programming runs and 1 after it ends.
- R7: When chip select rises after a low period shorter than TCS_CYC clocks, data-out stays disabled.
- R8: A frame with the wrong bit count (ended early or carrying extra bits) is discarded and leaves the array unchanged.
- R9: A frame whose opcode is not 00, or whose top address bits are neither 10 nor 01, leaves the array unchanged and starts no programming.
- R10: Frames sent while programming is running are ignored.
- R11: A ready status that is being driven is released (enable low) once a new start bit is clocked in with chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock, sampled on its rising edge |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value: 1 ready, 0 busy |
| do_oe_o | output | 1 | Data-out drive enable (low means high impedance) |
| rd_addr_i | input | 6 | Word select for the parallel read port |
| rd_data_o | output | 16 | Contents of the selected word |

## Verification
Each pin change reaches the logic two clocks later through the synchronizer. A serial clock edge is acted on in the third clock, and a chip-select rise enables status in the third clock after it. The end of programming shows on data-out exactly PROG_CYC+3 clocks after the chip-select pin falls. The bench holds every serial level for four clocks and samples at falling clock edges only after these latencies have elapsed. It counts clocks from the chip-select fall to the first ready sample and compares that count with PROG_CYC+3 exactly.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_ERASE = 2'd1,
    KIND_WRITE = 2'd2
  } frame_kind_e;

  localparam int          OP_W      = 2;
  localparam int          SEL_W     = 2;
  localparam logic [1:0]  OP_BULK   = 2'b00;
  localparam logic [1:0]  SEL_ERASE = 2'b10;
  localparam logic [1:0]  SEL_WRITE = 2'b01;

  // bits that follow the start bit in a fill-with-ones frame
  function automatic int erase_len(input int aw);
    return OP_W + aw;
  endfunction

  // bits that follow the start bit in a fill-with-data frame
  function automatic int write_len(input int aw, input int dw);
    return OP_W + aw + dw;
  endfunction

  // width needed for a counter that reaches n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/mwb_sync.sv
module mwb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= d_i;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mwb_shifter.sv
module mwb_shifter
  import mwb_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          cs_fall,
  input  logic          sk_rise,
  input  logic          di_s,
  input  logic          hold,
  output logic          in_frame,
  output logic          start_seen,
  output logic          erase_go,
  output logic          write_go,
  output logic [DW-1:0] wdata
);
  localparam int ELEN = erase_len(AW);
  localparam int WLEN = write_len(AW, DW);
  localparam int CW   = cnt_w(WLEN + 1);
  localparam int SW   = WLEN;

  logic          started_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sreg_q;
  frame_kind_e   kind;

  function automatic frame_kind_e decode(input logic [CW-1:0] n, input logic [SW-1:0] s);
    logic [OP_W-1:0]  e_op, w_op;
    logic [SEL_W-1:0] e_sel, w_sel;
    e_op  = s[ELEN-1 -: OP_W];
    e_sel = s[AW-1 -: SEL_W];
    w_op  = s[WLEN-1 -: OP_W];
    w_sel = s[DW+AW-1 -: SEL_W];
    if (n == CW'(ELEN) && e_op == OP_BULK && e_sel == SEL_ERASE) return KIND_ERASE;
    if (n == CW'(WLEN) && w_op == OP_BULK && w_sel == SEL_WRITE) return KIND_WRITE;
    return KIND_NONE;
  endfunction

  assign start_seen = cs_s && sk_rise && !hold && !started_q && di_s;
  assign kind       = decode(cnt_q, sreg_q);
  assign erase_go   = cs_fall && started_q && (kind == KIND_ERASE);
  assign write_go   = cs_fall && started_q && (kind == KIND_WRITE);
  assign wdata      = sreg_q[DW-1:0];
  assign in_frame   = started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      cnt_q     <= '0;
      sreg_q    <= '0;
    end else if (!cs_s) begin
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else if (sk_rise && !hold) begin
      if (!started_q) begin
        if (di_s) begin
          started_q <= 1'b1;
          cnt_q     <= '0;
        end
      end else begin
        sreg_q <= {sreg_q[SW-2:0], di_s};
        if (cnt_q != CW'(WLEN + 1)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_go || write_go) |-> (cnt_q == CW'(ELEN) || cnt_q == CW'(WLEN)));

endmodule

// File: rtl/mwb_timer.sv
module mwb_timer
  import mwb_pkg::*;
#(
  parameter int TCS_CYC  = 16,
  parameter int PROG_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic cs_rise,
  input  logic cs_fall,
  input  logic go,
  input  logic start_seen,
  output logic busy,
  output logic stat_en
);
  localparam int PW = cnt_w(PROG_CYC);
  localparam int LW = cnt_w(TCS_CYC);

  logic [PW-1:0] pcnt_q;
  logic [LW-1:0] low_q;
  logic          busy_q, lowok_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pcnt_q <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      pcnt_q <= '0;
    end else if (busy_q) begin
      if (pcnt_q == PW'(PROG_CYC - 1)) busy_q <= 1'b0;
      else pcnt_q <= pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else if (cs_s) low_q <= '0;
    else if (low_q != LW'(TCS_CYC)) low_q <= low_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowok_q <= 1'b0;
    else if (cs_fall) lowok_q <= 1'b0;
    else if (cs_rise) lowok_q <= (low_q >= LW'(TCS_CYC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (go) armed_q <= 1'b1;
    else if (start_seen) armed_q <= 1'b0;
  end

  assign busy    = busy_q;
  assign stat_en = cs_s && lowok_q && armed_q;

  // R5
  prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(go));

  // R5
  prog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pcnt_q < PW'(PROG_CYC)));

endmodule

// File: rtl/mwb_array.sv
module mwb_array #(
  parameter int WORDS = 64,
  parameter int DW    = 16,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_go,
  input  logic          write_go,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [WORDS];

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[g] <= '0;
        else if (erase_go) mem_q[g] <= '1;
        else if (write_go) mem_q[g] <= wdata;
      end
    end
  endgenerate

  assign rd_data = mem_q[rd_addr];

  // R2
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (mem_q[0] == '1 && mem_q[WORDS-1] == '1));

  // R3
  write_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (write_go && !erase_go) |=> (mem_q[0] == $past(wdata) && mem_q[WORDS-1] == $past(wdata)));

endmodule

// File: rtl/mwb_bulk_prog.sv
module mwb_bulk_prog
  import mwb_pkg::*;
#(
  parameter int WORDS    = 64,
  parameter int DW       = 16,
  parameter int TCS_CYC  = 16,
  parameter int PROG_CYC = 200,
  localparam int AW      = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          sk_i,
  input  logic          di_i,
  output logic          do_o,
  output logic          do_oe_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [2:0]    pins_s;
  logic          cs_s, sk_s, di_s;
  logic          cs_q, sk_q;
  logic          cs_rise, cs_fall, sk_rise;
  logic          in_frame, start_seen, erase_go, write_go, busy, stat_en;
  logic [DW-1:0] wdata;

  mwb_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_i, sk_i, di_i}), .q_o(pins_s)
  );
  assign {cs_s, sk_s, di_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs_s;
      sk_q <= sk_s;
    end
  end

  assign cs_rise = cs_s && !cs_q;
  assign cs_fall = !cs_s && cs_q;
  assign sk_rise = sk_s && !sk_q;

  mwb_shifter #(.AW(AW), .DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall), .sk_rise(sk_rise),
    .di_s(di_s), .hold(busy), .in_frame(in_frame), .start_seen(start_seen),
    .erase_go(erase_go), .write_go(write_go), .wdata(wdata)
  );

  mwb_timer #(.TCS_CYC(TCS_CYC), .PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .go(erase_go || write_go), .start_seen(start_seen), .busy(busy), .stat_en(stat_en)
  );

  mwb_array #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .erase_go(erase_go), .write_go(write_go),
    .wdata(wdata), .rd_addr(rd_addr_i), .rd_data(rd_data_o)
  );

  assign do_oe_o = stat_en;
  assign do_o    = stat_en && !busy;

  // R10
  idle_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_go || write_go) |-> !busy);

  // R4
  quiet_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |-> !do_oe_o);

  // R4
  quiet_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |-> !do_oe_o);

endmodule

// File: tb/sim_mwb_bulk_prog.sv
`timescale 1ns/1ps
module sim_mwb_bulk_prog;
  localparam int TCS  = 16;
  localparam int PROG = 200;
  localparam int HALF = 4;
  localparam int LAT  = PROG + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_v, do_oe;
  logic [5:0]  ra = '0;
  logic [15:0] rd;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  mwb_bulk_prog #(.TCS_CYC(TCS), .PROG_CYC(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_v), .do_oe_o(do_oe), .rd_addr_i(ra), .rd_data_o(rd)
  );

  // {is_write, addr_low[3:0], data[15:0], expected[15:0]}
  localparam logic [36:0] VEC [5] = '{
    {1'b1, 4'h3, 16'hA5C3, 16'hA5C3},
    {1'b0, 4'h0, 16'h0000, 16'hFFFF},
    {1'b1, 4'hF, 16'h0001, 16'h0001},
    {1'b1, 4'h8, 16'h8000, 16'h8000},
    {1'b0, 4'hA, 16'h1234, 16'hFFFF}
  };

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wt(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      di = v[i]; wt(HALF); sk = 1'b1; wt(HALF); sk = 1'b0;
    end
    wt(HALF);
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    cs = 1'b1; wt(HALF); bits(v, n); cs = 1'b0; di = 1'b0;
  endtask

  function automatic logic [31:0] erase_f(input logic [3:0] a);
    return {23'd0, 1'b1, 2'b00, 2'b10, a};
  endfunction

  function automatic logic [31:0] write_f(input logic [3:0] a, input logic [15:0] d);
    return {7'd0, 1'b1, 2'b00, 2'b01, a, d};
  endfunction

  // cs already low at call; returns clocks from the cs fall to first ready sample
  task automatic poll_ready(output int el);
    el = 0;
    wt(TCS + 4); el += TCS + 4;
    cs = 1'b1; wt(4); el += 4;
    while (!(do_oe && do_v) && el < 4000) begin wt(1); el++; end
  endtask

  task automatic words(input string tag, input logic [15:0] exp);
    ra = 6'd0;  wt(1); chk(tag, rd, exp);
    ra = 6'd31; wt(1); chk(tag, rd, exp);
    ra = 6'd63; wt(1); chk(tag, rd, exp);
  endtask

  initial begin
    int el;
    wt(3); rst_n = 1'b1; wt(3);
    // R1 reset state
    chk("R1 oe", do_oe, 0);
    words("R1 array", 16'h0000);

    // vector table: R2 / R3 / R5 / R6
    for (int k = 0; k < 5; k++) begin
      if (VEC[k][36]) frame(write_f(VEC[k][35:32], VEC[k][31:16]), 25);
      else            frame(erase_f(VEC[k][35:32]), 9);
      wt(TCS + 4); cs = 1'b1; wt(4);
      chk("R6 busy oe", do_oe, 1);
      chk("R6 busy do", do_v, 0);
      cs = 1'b0;
      // fresh low period then time the ready indication
      frame(32'd0, 0);
      cs = 1'b0;
      poll_ready(el);
      chk("R5 ready", el >= 4000 ? 0 : 1, 1);
      cs = 1'b0; wt(4);
      chk("R4 cs low oe", do_oe, 0);
      words(VEC[k][36] ? "R3 fill" : "R2 erase", VEC[k][15:0]);
    end

    // R5 exact latency
    frame(write_f(4'h0, 16'h5A5A), 25);
    poll_ready(el);
    chk("R5 latency", el, LAT);
    chk("R6 ready do", do_v, 1);

    // R11: start bit while ready releases status
    bits(32'd1, 1);
    chk("R11 release", do_oe, 0);
    // R4 mid-frame and R8 early end
    bits(32'h0, 5);
    chk("R4 shifting oe", do_oe, 0);
    cs = 1'b0; wt(8);
    words("R8 short", 16'h5A5A);

    // R8 wrong counts
    frame(write_f(4'h1, 16'h1111) >> 1, 24); wt(TCS + 4);
    frame(erase_f(4'h1) << 1, 10); wt(TCS + 4);
    words("R8 count", 16'h5A5A);

    // R9 bad opcode / bad select
    frame({23'd0, 1'b1, 2'b01, 2'b10, 4'h0}, 9); wt(TCS + 4);
    frame({23'd0, 1'b1, 2'b00, 2'b11, 4'h0}, 9);
    wt(TCS + 4); cs = 1'b1; wt(4);
    chk("R9 no prog oe", do_oe, 0);
    cs = 1'b0; wt(4);
    words("R9 array", 16'h5A5A);

    // R7 short deselect, then R10 frame while busy
    frame(write_f(4'h2, 16'h1234), 25);
    wt(5); cs = 1'b1; wt(4);
    chk("R7 short low", do_oe, 0);
    cs = 1'b0;
    frame(erase_f(4'h0), 9);
    poll_ready(el);
    chk("R10 ready", el >= 4000 ? 0 : 1, 1);
    cs = 1'b0; wt(4);
    words("R10 ignored", 16'h1234);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule